// File: doc/BRIEF.md
# Mailbox RPC Message Framer

The framer moves variable-length remote-procedure-call messages between a local message buffer and a mailbox with four word channels. A message is a header word followed by payload words. The header carries the total word count of the message, header included. When started, the framer reads the header from buffer address 0, checks the count against a maximum, and writes each word into the mailbox. The word at position k goes to channel k modulo 4, and the framer waits for that channel to report empty before each write.

Unless the caller asks for no response, a receive phase follows at once. The framer collects words from the mailbox in the same channel order, waiting for each channel to report full. It stores word k at buffer address k, so the request buffer is overwritten with the response. The received header is checked for size: an oversize header is stored as zero and the transfer ends. Each word wait is bounded by a cycle limit. When the limit runs out the operation ends with a timeout code. Every operation ends with a one-cycle done pulse that carries a 2-bit status.

Top module: `rpc_mbox_framer`

## Requirements
- R1: The header (position 0) travels on channel 0, and the word at position k travels on channel k mod 4. This holds for transmit (`tx_ch`) and for receive (`rx_ch`).
- R2: The word count is header bits 15:8. Exactly that many words are moved, header included. A count of 0 moves only the header.
- R3: On transmit, a header count above MAX_WORDS (default 8) ends the operation with status 1 (invalid size) before any `tx_we` pulse.
- R4: On receive, a header count above MAX_WORDS stores 0 at buffer address 0 and ends with status 1. No further `rx_re` pulse follows.
- R5: `tx_we` is raised only while `tx_empty[tx_ch]` is high, and `rx_re` only while `rx_full[rx_ch]` is high.
- R6: If the awaited flag stays low for TIMEOUT consecutive wait cycles (default 64), the operation ends with status 2 (timeout). The wait counter restarts for every word, so a message whose total wait exceeds TIMEOUT still succeeds when no single wait does.
- R7: With `no_resp`=1 only the transmit phase runs and the buffer is never written. With `no_resp`=0 the receive phase follows, and received word k is written to buffer address k.
- R8: `done` is a one-cycle pulse and `status` is valid with it. Status 0 means success. `busy` is high from the cycle after an accepted `start` until `done`, and `start` is accepted only while idle.
- R9: After reset the framer is idle, with `busy`, `done`, `tx_we`, `rx_re` and `buf_wr_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted while idle) |
| no_resp | input | 1 | 1: transmit only; 0: transmit then receive |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 success, 1 invalid size, 2 timeout |
| buf_rd_addr | output | 3 | Buffer read address |
| buf_rd_data | input | 32 | Buffer read data (combinational) |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_addr | output | 3 | Buffer write address |
| buf_wr_data | output | 32 | Buffer write data |
| tx_empty | input | 4 | Per-channel transmit empty flags |
| tx_we | output | 1 | Transmit write strobe |
| tx_ch | output | 2 | Transmit channel |
| tx_data | output | 32 | Transmit word |
| rx_full | input | 4 | Per-channel receive full flags |
| rx_re | output | 1 | Receive read strobe |
| rx_ch | output | 2 | Receive channel |
| rx_data | input | 32 | Receive word of the selected channel |

## Verification
Several properties are checked on every cycle: strobes happen only while the selected channel's flag is set, the channel follows a count of accepted strobes, done lasts one cycle, and no wait runs past the timeout window. Other behaviour shows only in the bench's scenarios. These are the word counts for lengths 0 to 8, payload contents in both directions, clearing of an oversize received header, rejection of an oversize request with no writes, stalls on a chosen channel in either phase, and a slow mailbox whose total wait exceeds the limit.

// File: rtl/rpc_framer_pkg.sv
package rpc_framer_pkg;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_BADSIZE = 2'd1,
        ST_TIMEOUT = 2'd2
    } fr_status_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TX_CHECK,
        PH_TX_WAIT,
        PH_RX_WAIT,
        PH_FINISH
    } fr_phase_e;

endpackage

// File: rtl/rpc_size_check.sv
module rpc_size_check #(
    parameter int WORD_W    = 32,
    parameter int SIZE_LSB  = 8,
    parameter int SIZE_W    = 8,
    parameter int MAX_WORDS = 8,
    parameter int IDX_W     = 4
) (
    input  logic [WORD_W-1:0] header,
    output logic              oversize,
    output logic [IDX_W-1:0]  total
);
    logic [SIZE_W-1:0] size_field;

    always_comb begin
        size_field = header[SIZE_LSB +: SIZE_W];
        oversize   = (int'(size_field) > MAX_WORDS);
        if (size_field == '0)
            total = IDX_W'(1);
        else
            total = IDX_W'(size_field);
    end
endmodule

// File: rtl/rpc_word_timer.sv
module rpc_word_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic waiting,
    input  logic flag,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!waiting || flag)
            cnt_d = '0;
        else
            cnt_d = cnt_q + CNT_W'(1);
        expired = waiting && !flag && (cnt_q == CNT_W'(LIMIT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rpc_mbox_framer.sv
module rpc_mbox_framer
    import rpc_framer_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int MAX_WORDS = 8,
    parameter int N_CH      = 4,
    parameter int TIMEOUT   = 64,
    parameter int SIZE_LSB  = 8,
    parameter int SIZE_W    = 8,
    localparam int ADDR_W   = $clog2(MAX_WORDS),
    localparam int CH_W     = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              no_resp,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [ADDR_W-1:0] buf_rd_addr,
    input  logic [WORD_W-1:0] buf_rd_data,
    output logic              buf_wr_en,
    output logic [ADDR_W-1:0] buf_wr_addr,
    output logic [WORD_W-1:0] buf_wr_data,
    input  logic [N_CH-1:0]   tx_empty,
    output logic              tx_we,
    output logic [CH_W-1:0]   tx_ch,
    output logic [WORD_W-1:0] tx_data,
    input  logic [N_CH-1:0]   rx_full,
    output logic              rx_re,
    output logic [CH_W-1:0]   rx_ch,
    input  logic [WORD_W-1:0] rx_data
);
    localparam int IDX_W = $clog2(MAX_WORDS + 1);

    typedef struct packed {
        fr_phase_e   phase;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] total;
        fr_status_e  stat;
        logic        one_way;
    } fr_regs_t;

    fr_regs_t r_d, r_q;

    logic [WORD_W-1:0] hdr_word;
    logic              hdr_oversize;
    logic [IDX_W-1:0]  hdr_total;
    logic              waiting, flag_now, expired;
    logic [CH_W-1:0]   cur_ch;
    logic              last_word;

    rpc_size_check #(
        .WORD_W(WORD_W), .SIZE_LSB(SIZE_LSB), .SIZE_W(SIZE_W),
        .MAX_WORDS(MAX_WORDS), .IDX_W(IDX_W)
    ) u_size (
        .header  (hdr_word),
        .oversize(hdr_oversize),
        .total   (hdr_total)
    );

    rpc_word_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .waiting(waiting),
        .flag   (flag_now),
        .expired(expired)
    );

    always_comb begin
        cur_ch    = r_q.idx[CH_W-1:0];
        hdr_word  = (r_q.phase == PH_RX_WAIT) ? rx_data : buf_rd_data;
        waiting   = (r_q.phase == PH_TX_WAIT) || (r_q.phase == PH_RX_WAIT);
        flag_now  = (r_q.phase == PH_TX_WAIT) ? tx_empty[cur_ch] :
                    (r_q.phase == PH_RX_WAIT) ? rx_full[cur_ch] : 1'b0;
        last_word = ((r_q.idx + IDX_W'(1)) == r_q.total);

        r_d         = r_q;
        buf_rd_addr = r_q.idx[ADDR_W-1:0];
        buf_wr_en   = 1'b0;
        buf_wr_addr = r_q.idx[ADDR_W-1:0];
        buf_wr_data = rx_data;
        tx_we       = 1'b0;
        tx_ch       = cur_ch;
        tx_data     = buf_rd_data;
        rx_re       = 1'b0;
        rx_ch       = cur_ch;

        unique case (r_q.phase)
            PH_IDLE: begin
                if (start) begin
                    r_d.phase   = PH_TX_CHECK;
                    r_d.idx     = '0;
                    r_d.one_way = no_resp;
                    r_d.stat    = ST_OK;
                end
            end
            PH_TX_CHECK: begin
                if (hdr_oversize) begin
                    r_d.stat  = ST_BADSIZE;
                    r_d.phase = PH_FINISH;
                end else begin
                    r_d.total = hdr_total;
                    r_d.phase = PH_TX_WAIT;
                end
            end
            PH_TX_WAIT: begin
                if (tx_empty[cur_ch]) begin
                    tx_we = 1'b1;
                    if (last_word) begin
                        r_d.idx   = '0;
                        r_d.phase = r_q.one_way ? PH_FINISH : PH_RX_WAIT;
                    end else begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                    end
                end else if (expired) begin
                    r_d.stat  = ST_TIMEOUT;
                    r_d.phase = PH_FINISH;
                end
            end
            PH_RX_WAIT: begin
                if (rx_full[cur_ch]) begin
                    rx_re     = 1'b1;
                    buf_wr_en = 1'b1;
                    if (r_q.idx == '0) begin
                        if (hdr_oversize) begin
                            buf_wr_data = '0;
                            r_d.stat    = ST_BADSIZE;
                            r_d.phase   = PH_FINISH;
                        end else if (hdr_total == IDX_W'(1)) begin
                            r_d.phase = PH_FINISH;
                        end else begin
                            r_d.total = hdr_total;
                            r_d.idx   = IDX_W'(1);
                        end
                    end else if (last_word) begin
                        r_d.phase = PH_FINISH;
                    end else begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                    end
                end else if (expired) begin
                    r_d.stat  = ST_TIMEOUT;
                    r_d.phase = PH_FINISH;
                end
            end
            PH_FINISH: r_d.phase = PH_IDLE;
            default:   r_d.phase = PH_IDLE;
        endcase

        busy   = (r_q.phase != PH_IDLE) && (r_q.phase != PH_FINISH);
        done   = (r_q.phase == PH_FINISH);
        status = r_q.stat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.phase   <= PH_IDLE;
            r_q.idx     <= '0;
            r_q.total   <= '0;
            r_q.stat    <= ST_OK;
            r_q.one_way <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    // Observation counters for the assertions: strobes seen since start.
    logic [CH_W-1:0] tx_seen_q, rx_seen_q;
    logic [$clog2(TIMEOUT + 4)-1:0] stall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_seen_q <= '0;
            rx_seen_q <= '0;
            stall_q   <= '0;
        end else begin
            if (start && !busy)  tx_seen_q <= '0;
            else if (tx_we)      tx_seen_q <= tx_seen_q + CH_W'(1);
            if (start && !busy)  rx_seen_q <= '0;
            else if (rx_re)      rx_seen_q <= rx_seen_q + CH_W'(1);
            if (!busy || tx_we || rx_re) stall_q <= '0;
            else                         stall_q <= stall_q + 1'b1;
        end
    end

    AST_TX_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_we |-> tx_empty[tx_ch]); // R5
    AST_RX_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_re |-> rx_full[rx_ch]); // R5
    AST_TX_CH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        tx_we |-> (tx_ch == tx_seen_q)); // R1
    AST_RX_CH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        rx_re |-> (rx_ch == rx_seen_q)); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        int'(stall_q) <= TIMEOUT + 1); // R6
    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tx_we && !rx_re && !buf_wr_en)); // R9
endmodule

// File: tb/tb_rpc_mbox_framer.sv
`timescale 1ns/1ps
module tb_rpc_mbox_framer;
    localparam int TMO = 64;
    localparam int DLY = TMO - 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        start = 1'b0, no_resp = 1'b1;
    logic        busy, done;
    logic [1:0]  status;
    logic [2:0]  buf_rd_addr, buf_wr_addr;
    logic [31:0] buf_rd_data, buf_wr_data;
    logic        buf_wr_en;
    logic [3:0]  tx_empty, rx_full;
    logic        tx_we, rx_re;
    logic [1:0]  tx_ch, rx_ch;
    logic [31:0] tx_data, rx_data;

    rpc_mbox_framer #(.TIMEOUT(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .no_resp(no_resp),
        .busy(busy), .done(done), .status(status),
        .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
        .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
        .tx_empty(tx_empty), .tx_we(tx_we), .tx_ch(tx_ch), .tx_data(tx_data),
        .rx_full(rx_full), .rx_re(rx_re), .rx_ch(rx_ch), .rx_data(rx_data)
    );

    // Behavioural buffer and mailbox
    logic [31:0] mem [0:7];
    logic [31:0] resp [0:15];
    int          resp_len = 0;
    int          rx_ptr = 0;
    logic [3:0]  tx_block = 4'h0;
    logic        slow = 1'b0;
    int          dly = 0;
    logic [1:0]  log_ch [0:15];
    logic [31:0] log_dat [0:15];
    int          log_n = 0;
    logic        clr = 1'b0;

    assign buf_rd_data = mem[buf_rd_addr];
    assign tx_empty = slow ? ((dly >= DLY) ? 4'hF : 4'h0) : ~tx_block;
    assign rx_full  = (rx_ptr < resp_len) ? (4'b0001 << rx_ptr[1:0]) : 4'h0;
    assign rx_data  = (rx_ptr < resp_len && rx_ch == rx_ptr[1:0]) ? resp[rx_ptr] : 32'hDEAD_BEEF;

    always @(posedge clk) begin
        if (buf_wr_en) mem[buf_wr_addr] <= buf_wr_data;
        if (clr) begin
            log_n <= 0; rx_ptr <= 0; dly <= 0;
        end else begin
            if (tx_we) begin
                if (log_n < 16) begin
                    log_ch[log_n]  <= tx_ch;
                    log_dat[log_n] <= tx_data;
                end
                log_n <= log_n + 1;
            end
            if (rx_re) rx_ptr <= rx_ptr + 1;
            if (tx_we) dly <= 0;
            else if (dly < DLY) dly <= dly + 1;
        end
    end

    int checks = 0, fails = 0;
    logic [1:0] st;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic prep();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic run(input logic nr);
        int n;
        no_resp = nr;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk); n++;
        end
        st = status;
        @(negedge clk);
    endtask

    task automatic load(input int cnt, input int size);
        mem[0] = {16'h0, size[7:0], 8'h5A};
        for (int k = 1; k < 8; k++) mem[k] = 32'hC000_0000 + cnt * 32'h100 + k;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) mem[k] = '0;
        for (int k = 0; k < 16; k++) resp[k] = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 busy", busy, 0);
        chk("R9 done", done, 0);
        chk("R9 strobes", {tx_we, rx_re, buf_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R7: transmit only, sizes 0..8
        for (int sz = 0; sz <= 8; sz++) begin
            int tot;
            tot = (sz == 0) ? 1 : sz;
            load(sz, sz);
            prep();
            run(1'b1);
            chk("R8 status ok", st, 0);
            chk("R2 word count", log_n, tot);
            chk("R7 buffer untouched", mem[0], {16'h0, 8'(sz), 8'h5A});
            for (int k = 0; k < tot; k++) begin
                chk("R1 tx channel", log_ch[k], k % 4);
                chk("R1 tx data", log_dat[k], mem[k]);
            end
        end

        // R7 R1 R2: request then response of length 9-n
        for (int sz = 1; sz <= 8; sz++) begin
            int m;
            m = 9 - sz;
            load(sz, sz);
            resp[0] = {16'h0, 8'(m), 8'h77};
            for (int k = 1; k < 16; k++) resp[k] = 32'hA500_0000 + sz * 32'h10 + k;
            resp_len = 16;
            prep();
            run(1'b0);
            chk("R8 status ok rx", st, 0);
            chk("R2 tx count", log_n, sz);
            chk("R2 rx count", rx_ptr, m);
            for (int k = 0; k < m; k++) chk("R7 rx stored", mem[k], resp[k]);
        end

        // R3 oversize request
        load(9, 9);
        prep();
        run(1'b1);
        chk("R3 status", st, 1);
        chk("R3 no writes", log_n, 0);

        // R4 oversize response
        load(2, 2);
        resp[0] = {16'h0, 8'd12, 8'h33};
        resp_len = 16;
        prep();
        run(1'b0);
        chk("R4 status", st, 1);
        chk("R4 header cleared", mem[0], 0);
        chk("R4 single read", rx_ptr, 1);
        chk("R4 old payload kept", mem[1], 32'hC000_0201);

        // R6 stall on transmit channel 2
        load(5, 5);
        tx_block = 4'b0100;
        prep();
        run(1'b1);
        tx_block = 4'h0;
        chk("R6 tx timeout", st, 2);
        chk("R6 words before stall", log_n, 2);

        // R6 stall on receive channel 3 (header promises 6, 3 arrive)
        load(1, 1);
        resp[0] = {16'h0, 8'd6, 8'h11};
        resp[1] = 32'h1111_0001; resp[2] = 32'h1111_0002;
        resp_len = 3;
        prep();
        run(1'b0);
        chk("R6 rx timeout", st, 2);
        chk("R6 rx words", rx_ptr, 3);
        chk("R6 rx stored", mem[2], 32'h1111_0002);

        // R6 per-word restart with a slow mailbox, R5 flags
        load(4, 4);
        slow = 1'b1;
        prep();
        run(1'b1);
        slow = 1'b0;
        chk("R6 slow ok", st, 0);
        chk("R5 slow count", log_n, 4);

        // R8 start ignored while busy: second start mid-operation
        load(3, 3);
        tx_block = 4'b0010;
        prep();
        no_resp = 1'b1;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        tx_block = 4'h0;
        repeat (5) @(negedge clk);
        chk("R8 no restart", log_n, 3);
        chk("R8 idle after", busy, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule